// File: doc/BRIEF.md
# Memory Power State Sequencer

This block sits on the controller side of an SDRAM rank. It chooses how deeply the rank rests while no traffic is pending, and it holds back a new access until the wake-up time of the current rest state has passed. There are five rest levels: two open-page levels, two closed-page levels, and sleep. In each pair, one level keeps the memory clock running and the other stops it. Sleep is the deepest level. Each level costs a different number of memory clocks to leave. The block counts that cost in controller clocks, at a fixed number of controller clocks per memory clock.

While the rank is idle, two policy inputs choose the rest level: one closes the page and one stops the clock. A sleep request takes priority over both. The only way out of sleep is an access. When an access is requested, the sequencer loads the exit latency of the current level into a down-counter and raises busy. It gives a one-cycle grant when the count runs out, and it then places the rank in the open-page, clock-running level. A sleep request that arrives during a wake-up is remembered and is carried out once the rank is idle again.

Top module: `pwr_state_seq`

## Requirements
- R1: During and after synchronous reset, state_o is 0 (open page, clock running), busy_o is 0 and grant_o is 0.
- R2: When idle_i is high, acc_req_i and sleep_req_i are low, no sleep is pending and the state is not sleep, the next edge sets state_o to {clk_stop_i, page_close_i}. The codes are 0 = open page with clock on, 1 = closed page with clock on, 2 = open page with clock off and 3 = closed page with clock off.
- R3: While idle_i is low and no grant is given, state_o does not change.
- R4: Sleep (state_o = 4) is entered only from an idle rank with no access request, at the edge after sleep_req_i is seen. Sleep takes priority over the policy inputs.
- R5: In state 0, an access request sampled at an edge produces grant_o high after that same edge, with busy_o staying low.
- R6: In states 1, 2, 3 and 4, an access request sampled at edge e0 raises busy_o for exactly L cycles, with grant_o high after edge e0+L. L is 15, 5, 20 and 1000 respectively (3, 1, 4 and 200 memory clocks times 5).
- R7: Access requests during a countdown have no further effect. At the grant, busy_o falls and state_o becomes 0. grant_o and busy_o are never high together.
- R8: A sleep request seen during a countdown is held. After the grant, the rank enters sleep at the first edge where idle_i is high and no access is requested, even if sleep_req_i is low by then.
- R9: Once in sleep, the state stays 4 whatever the policy and sleep inputs do, until an access is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| idle_i | input | 1 | Rank has no outstanding traffic |
| page_close_i | input | 1 | Policy: close the page while resting |
| clk_stop_i | input | 1 | Policy: stop the memory clock while resting |
| sleep_req_i | input | 1 | Request for the sleep level |
| acc_req_i | input | 1 | Access request, held until granted |
| state_o | output | 3 | Current rest level code (0 to 4) |
| busy_o | output | 1 | High during every cycle of an exit countdown |
| grant_o | output | 1 | One-cycle access grant |

## Verification
The hardest situation to reach is a sleep request that lands in the middle of a long exit countdown and must survive the grant. To reach it, the stimulus raises the sleep request during a 20-cycle wake-up, holds idle low until after the grant, and only then raises idle. The 1000-cycle sleep exit is reached deliberately by a directed sequence. The random phase keeps the access probability low so that several further sleep wake-ups occur naturally.

// File: rtl/pss_pkg.sv
`timescale 1ns/1ps
package pss_pkg;
  typedef enum logic [2:0] {
    PS_OPEN_RUN  = 3'd0,
    PS_SHUT_RUN  = 3'd1,
    PS_OPEN_HALT = 3'd2,
    PS_SHUT_HALT = 3'd3,
    PS_DEEP      = 3'd4
  } pstate_t;

  localparam int unsigned NUM_LEVELS = 5;

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/pss_lat_lut.sv
`timescale 1ns/1ps
module pss_lat_lut import pss_pkg::*; #(
  parameter int unsigned CPU_PER_MCLK  = 5,
  parameter int unsigned LAT_SHUT_RUN  = 3,
  parameter int unsigned LAT_OPEN_HALT = 1,
  parameter int unsigned LAT_SHUT_HALT = 4,
  parameter int unsigned LAT_DEEP      = 200,
  parameter int unsigned CW            = 10
) (
  input  pstate_t        level,
  output logic [CW-1:0]  lat
);
  localparam int unsigned MC_LAT [NUM_LEVELS] =
    '{0, LAT_SHUT_RUN, LAT_OPEN_HALT, LAT_SHUT_HALT, LAT_DEEP};

  logic [CW-1:0] tbl [NUM_LEVELS];

  for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_tbl
    assign tbl[i] = CW'(MC_LAT[i] * CPU_PER_MCLK);
  end

  always_comb begin
    lat = '0;
    for (int k = 0; k < NUM_LEVELS; k++) begin
      if (level == pstate_t'(k)) lat = tbl[k];
    end
  end
endmodule

// File: rtl/pss_cnt.sv
`timescale 1ns/1ps
module pss_cnt #(
  parameter int unsigned CW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          active,
  output logic          last
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (load)          cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - CW'(1);
  end

  assign active = (cnt != '0);
  assign last   = (cnt == CW'(1));
endmodule

// File: rtl/pss_policy.sv
`timescale 1ns/1ps
module pss_policy import pss_pkg::*; (
  input  logic    page_close,
  input  logic    clk_stop,
  output pstate_t target
);
  always_comb begin
    unique case ({clk_stop, page_close})
      2'b00:   target = PS_OPEN_RUN;
      2'b01:   target = PS_SHUT_RUN;
      2'b10:   target = PS_OPEN_HALT;
      default: target = PS_SHUT_HALT;
    endcase
  end
endmodule

// File: rtl/pwr_state_seq.sv
`timescale 1ns/1ps
module pwr_state_seq import pss_pkg::*; #(
  parameter int unsigned CPU_PER_MCLK  = 5,
  parameter int unsigned LAT_SHUT_RUN  = 3,
  parameter int unsigned LAT_OPEN_HALT = 1,
  parameter int unsigned LAT_SHUT_HALT = 4,
  parameter int unsigned LAT_DEEP      = 200
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       idle_i,
  input  logic       page_close_i,
  input  logic       clk_stop_i,
  input  logic       sleep_req_i,
  input  logic       acc_req_i,
  output logic [2:0] state_o,
  output logic       busy_o,
  output logic       grant_o
);
  localparam int unsigned MAX_MC =
    max_of(max_of(LAT_SHUT_RUN, LAT_OPEN_HALT), max_of(LAT_SHUT_HALT, LAT_DEEP));
  localparam int unsigned MAX_LAT = MAX_MC * CPU_PER_MCLK;
  localparam int unsigned CW      = $clog2(MAX_LAT + 1) + 1;

  pstate_t       level_q;
  pstate_t       pol_target;
  logic [CW-1:0] exit_lat;
  logic          cnt_active, cnt_last, cnt_load;
  logic          sleep_pend_q, busy_q, grant_q;

  pss_lat_lut #(
    .CPU_PER_MCLK (CPU_PER_MCLK),
    .LAT_SHUT_RUN (LAT_SHUT_RUN),
    .LAT_OPEN_HALT(LAT_OPEN_HALT),
    .LAT_SHUT_HALT(LAT_SHUT_HALT),
    .LAT_DEEP     (LAT_DEEP),
    .CW           (CW)
  ) u_lut (
    .level(level_q),
    .lat  (exit_lat)
  );

  pss_policy u_pol (
    .page_close(page_close_i),
    .clk_stop  (clk_stop_i),
    .target    (pol_target)
  );

  assign cnt_load = !cnt_active && acc_req_i && (exit_lat != '0);

  pss_cnt #(.CW(CW)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .load    (cnt_load),
    .load_val(exit_lat),
    .active  (cnt_active),
    .last    (cnt_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q      <= PS_OPEN_RUN;
      sleep_pend_q <= 1'b0;
      busy_q       <= 1'b0;
      grant_q      <= 1'b0;
    end else begin
      grant_q <= 1'b0;
      if (cnt_active) begin
        if (sleep_req_i) sleep_pend_q <= 1'b1;
        if (cnt_last) begin
          busy_q  <= 1'b0;
          grant_q <= 1'b1;
          level_q <= PS_OPEN_RUN;
        end
      end else if (acc_req_i) begin
        if (exit_lat == '0) grant_q <= 1'b1;
        else                busy_q  <= 1'b1;
      end else if (idle_i && (sleep_req_i || sleep_pend_q)) begin
        level_q      <= PS_DEEP;
        sleep_pend_q <= 1'b0;
      end else if (idle_i && level_q != PS_DEEP) begin
        level_q <= pol_target;
      end
    end
  end

  assign state_o = level_q;
  assign busy_o  = busy_q;
  assign grant_o = grant_q;
endmodule

// File: rtl/pss_checker.sv
`timescale 1ns/1ps
module pss_checker (
  input logic       clk,
  input logic       rst,
  input logic       idle_i,
  input logic [2:0] state_o,
  input logic       busy_o,
  input logic       grant_o
);
  // R7: grant and busy are exclusive
  a_r7_grant_not_busy: assert property (@(posedge clk) disable iff (rst)
    !(grant_o && busy_o));

  // R7: end of countdown coincides with grant into the open running level
  a_r7_fall_grants: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (grant_o && state_o == 3'd0));

  // R3: without idle and without a grant the level holds
  a_r3_hold_not_idle: assert property (@(posedge clk) disable iff (rst)
    (!$past(idle_i) && !grant_o) |-> $stable(state_o));

  // R4: sleep is entered only from an idle rank
  a_r4_sleep_needs_idle: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd4 && $past(state_o) != 3'd4) |-> $past(idle_i));

  // R9: sleep is left only through a grant
  a_r9_sleep_exit_grant: assert property (@(posedge clk) disable iff (rst)
    ($past(state_o) == 3'd4 && state_o != 3'd4) |-> grant_o);

  // R6: level does not move while a countdown runs
  a_r6_stable_in_count: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> $stable(state_o));

  // R2: only legal level codes appear
  a_r2_code_range: assert property (@(posedge clk) disable iff (rst)
    state_o <= 3'd4);
endmodule

bind pwr_state_seq pss_checker u_chk (
  .clk    (clk),
  .rst    (rst),
  .idle_i (idle_i),
  .state_o(state_o),
  .busy_o (busy_o),
  .grant_o(grant_o)
);

// File: tb/sim_pwr_state_seq.sv
`timescale 1ns/1ps
module sim_pwr_state_seq;
  logic clk = 1'b0;
  logic rst;
  logic idle_i, page_close_i, clk_stop_i, sleep_req_i, acc_req_i;
  logic [2:0] state_o;
  logic busy_o, grant_o;

  int n_chk = 0;
  int n_bad = 0;
  string tag = "R1";

  int m_state, m_cnt;
  bit m_busy, m_grant, m_pend;

  always #2 clk = ~clk;

  pwr_state_seq u0 (
    .clk(clk), .rst(rst), .idle_i(idle_i), .page_close_i(page_close_i),
    .clk_stop_i(clk_stop_i), .sleep_req_i(sleep_req_i), .acc_req_i(acc_req_i),
    .state_o(state_o), .busy_o(busy_o), .grant_o(grant_o)
  );

  function automatic int exit_cycles(input int s);
    case (s)
      1: return 15;
      2: return 5;
      3: return 20;
      4: return 1000;
      default: return 0;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_state = 0; m_cnt = 0; m_busy = 0; m_grant = 0; m_pend = 0;
  endtask

  task automatic tick();
    bit a, i, pc, cs, sr;
    a = acc_req_i; i = idle_i; pc = page_close_i; cs = clk_stop_i; sr = sleep_req_i;
    @(posedge clk);
    m_grant = 0;
    if (m_cnt > 0) begin
      if (sr) m_pend = 1;
      if (m_cnt == 1) begin m_cnt = 0; m_busy = 0; m_grant = 1; m_state = 0; end
      else m_cnt--;
    end else if (a) begin
      if (exit_cycles(m_state) == 0) m_grant = 1;
      else begin m_cnt = exit_cycles(m_state); m_busy = 1; end
    end else if (i && (sr || m_pend)) begin
      m_state = 4; m_pend = 0;
    end else if (i && m_state != 4) begin
      m_state = {cs, pc};
    end
    #1;
    check(state_o == 3'(m_state) && busy_o == m_busy && grant_o == m_grant, tag,
          {state_o, busy_o, grant_o}, {3'(m_state), m_busy, m_grant});
  endtask

  task automatic set_level(input int lv);
    acc_req_i = 0; idle_i = 1;
    if (lv == 4) begin sleep_req_i = 1; tick(); sleep_req_i = 0; end
    else begin page_close_i = lv[0]; clk_stop_i = lv[1]; sleep_req_i = 0; tick(); end
  endtask

  task automatic wake(input int exp, input string req);
    int n = 0;
    acc_req_i = 1;
    tag = req;
    tick();
    while (!grant_o && n < 2000) begin
      if (busy_o) n++;
      tick();
    end
    check(n == exp, req, n, exp);
    check(state_o == 3'd0, req, state_o, 0);
    acc_req_i = 0;
  endtask

  initial begin
    #600000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    rst = 1; idle_i = 0; page_close_i = 0; clk_stop_i = 0; sleep_req_i = 0; acc_req_i = 0;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    check(state_o == 0 && !busy_o && !grant_o, "R1", {state_o, busy_o, grant_o}, 0);
    rst = 0;
    tag = "R1"; tick();

    // R2: each policy combination while idle
    for (int lv = 0; lv < 4; lv++) begin
      tag = "R2"; set_level(lv);
      check(state_o == 3'(lv), "R2", state_o, lv);
    end
    // R3: not idle, policy moves ignored
    idle_i = 0; page_close_i = 0; clk_stop_i = 1; tag = "R3";
    repeat (3) tick();
    check(state_o == 3'd3, "R3", state_o, 3);
    // R4: sleep refused while busy with traffic, then honoured
    sleep_req_i = 1; tag = "R4"; tick();
    check(state_o == 3'd3, "R4", state_o, 3);
    idle_i = 1; tick();
    check(state_o == 3'd4, "R4", state_o, 4);
    // R9: sticky sleep
    sleep_req_i = 0; page_close_i = 1; clk_stop_i = 0; tag = "R9";
    repeat (4) tick();
    check(state_o == 3'd4, "R9", state_o, 4);
    // R6: every exit latency
    wake(1000, "R6");
    for (int lv = 1; lv < 4; lv++) begin
      tag = "R6"; set_level(lv);
      wake(exit_cycles(lv), "R6");
    end
    // R5: immediate grant
    set_level(0);
    acc_req_i = 1; tag = "R5"; tick();
    check(grant_o && !busy_o, "R5", {busy_o, grant_o}, 1);
    acc_req_i = 0; tick();
    // R8 and R7: sleep request and extra requests inside a countdown
    set_level(3);
    idle_i = 0; acc_req_i = 1; tag = "R8"; tick();
    sleep_req_i = 1; repeat (3) tick();
    sleep_req_i = 0;
    while (!grant_o) tick();
    check(!busy_o && state_o == 0, "R7", {state_o, busy_o}, 0);
    acc_req_i = 0; tick();
    check(state_o == 3'd0, "R8", state_o, 0);
    idle_i = 1; tick();
    check(state_o == 3'd4, "R8", state_o, 4);

    // random phase
    tag = "R6";
    for (int c = 0; c < 6000; c++) begin
      idle_i       = ($urandom_range(0, 9) < 7);
      page_close_i = $urandom_range(0, 1);
      clk_stop_i   = $urandom_range(0, 1);
      sleep_req_i  = ($urandom_range(0, 19) == 0);
      if (grant_o) acc_req_i = 0;
      else if (!acc_req_i) acc_req_i = ($urandom_range(0, 29) == 0);
      tick();
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule